// File: doc/BRIEF.md
# Cascaded Capture Timer

This block joins two 16-bit up/down counters into one 32-bit count. The lower counter steps on an enable strobe. Each time it wraps, it produces a carry event, and the carry event clocks the upper counter. The lower half has a capture register fed by a synchronised, edge-selected external strobe. Behind that capture register sits an optional buffer register. The upper half has a compare register and a second register that records the upper count whenever a compare hit occurs. Four auxiliary registers record the upper count on every carry event.

A host reaches the registers through a two-cycle bus access. In the first cycle (T1) the host presents the address and the write flag. In the second cycle (T2) it presents the data. Sometimes a bus access and an internal event land in the same cycle. The block settles these cases with fixed priorities:
- A capture-driven buffer transfer overrides a host write to the buffer.
- A host write to the lower counter overrides the carry into the upper counter.
- Compare and capture events derived from that carry still take place.

Top module: `cascap_timer`

## Requirements
- R1: After reset, every register reads 0, and `cmp_a_o` and `carry_o` are 0.
- R2: With `dir_lo`=1, each cycle with `count_en` high adds 1 to the lower counter. A wrap from 0xFFFF to 0x0000 is a carry event, which steps the upper counter in its own direction. With both directions up, {upper, lower} counts as one 32-bit value.
- R3: With `dir_lo`=0 and `dir_hi`=0, each enabled cycle subtracts 1. A wrap from 0x0000 to 0xFFFF borrows 1 from the upper counter.
- R4: Addresses are 0 lower count, 1 upper count, 2 lower capture, 3 lower buffer, 4 upper compare, 5 upper B register, and 8..11 auxiliary registers 0..3 (read only). Any other address reads 0.
  - A write takes effect at the clock edge that ends T2.
  - `bus_rdata` is updated at that same edge with the value the register held during T2.
- R5: `edge_sel` chooses the capture edge: 0 none, 1 rising, 2 falling, 3 both.
  - `cap_in` passes through two flip-flops before edge detection.
  - A selected edge loads the lower count into the capture register two edges after `cap_in` is first sampled.
  - An edge that is not selected changes nothing.
  - A capture beats a host write to the capture register in the same cycle.
- R6: With `buf_en`=1, a capture moves the old capture value into the buffer in the same cycle.
- R7: If a capture with `buf_en`=1 falls in the T2 cycle of a buffer write, the transfer wins and the written data is discarded.
- R8: If a lower-counter write lands in T2 in a cycle where the lower counter wraps, the written value is loaded. The upper counter does not step, and `carry_o` stays low.
- R9: On every carry event, whether or not it is suppressed, the upper count is compared with the compare register. On a match, `cmp_a_o` pulses high for one cycle after the edge, and the B register loads the upper count.
- R10: All four auxiliary registers load the current upper count on every carry event, including a suppressed one.
- R11: `clr_both` clears both counters at the same edge. It overrides counting and blocks the carry, but a counter write in T2 overrides it.
- R12: `carry_o` pulses for one cycle after each carry that actually steps the upper counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| bus_t1 | input | 1 | Address cycle of a bus access |
| bus_t2 | input | 1 | Data cycle of a bus access |
| bus_we | input | 1 | Write flag, sampled in T1 |
| bus_addr | input | 4 | Register address, sampled in T1 |
| bus_wdata | input | 16 | Write data, sampled in T2 |
| bus_rdata | output | 16 | Read data, valid after T2 |
| count_en | input | 1 | Step strobe for the lower counter |
| dir_lo | input | 1 | Lower direction, 1 = up |
| dir_hi | input | 1 | Upper direction, 1 = up |
| clr_both | input | 1 | Clear both counters |
| cap_in | input | 1 | Asynchronous capture input |
| edge_sel | input | 2 | Capture edge selection |
| buf_en | input | 1 | Enable the capture buffer |
| cmp_a_o | output | 1 | Upper compare hit pulse |
| carry_o | output | 1 | Delivered carry pulse |

## Verification
The bench targets two same-cycle collisions.

The first is a capture strobe that coincides with the T2 cycle of a buffer write. The bench raises `cap_in` one cycle before T1, which puts the detected edge exactly in T2. It then reads back the buffer and expects the old capture value instead of the written data.

The second is a lower-counter write whose T2 cycle carries the step from 0xFFFF. Here the bench expects:
- the written value in the lower counter;
- an unchanged upper counter and no `carry_o` pulse;
- a `cmp_a_o` pulse, with the B register and auxiliary registers holding the upper count.

// File: rtl/cct_pkg.sv
package cct_pkg;
   localparam logic [3:0] A_LO_CNT  = 4'd0;
   localparam logic [3:0] A_HI_CNT  = 4'd1;
   localparam logic [3:0] A_LO_CAP  = 4'd2;
   localparam logic [3:0] A_LO_BUF  = 4'd3;
   localparam logic [3:0] A_HI_CMP  = 4'd4;
   localparam logic [3:0] A_HI_REGB = 4'd5;
   localparam logic [3:0] A_AUX0    = 4'd8;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_BOTH = 2'd3
   } edge_sel_e;
endpackage

// File: rtl/cct_bus.sv
module cct_bus #(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          t1,
   input  logic          t2,
   input  logic          we,
   input  logic [AW-1:0] addr,
   output logic [AW-1:0] acc_addr,
   output logic          wr_stb,
   output logic          rd_stb
);
   logic we_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_addr <= '0;
         we_q     <= 1'b0;
      end else if (t1) begin
         acc_addr <= addr;
         we_q     <= we;
      end
   end

   assign wr_stb = t2 && we_q;
   assign rd_stb = t2 && !we_q;

   // R4: the data cycle always follows an address cycle
   a_r4_t2_after_t1: assert property (@(posedge clk) disable iff (!rst_n)
      t2 |-> $past(t1));
endmodule

// File: rtl/cct_capsync.sv
module cct_capsync #(
   parameter int SYNC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       din,
   input  logic [1:0] edge_sel,
   output logic       evt
);
   import cct_pkg::*;

   if (SYNC < 2) begin : g_bad_sync
      $error("cct_capsync: SYNC must be at least 2");
   end

   logic [SYNC-1:0] sr;
   logic            prev;
   logic            rise, fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr   <= '0;
         prev <= 1'b0;
      end else begin
         sr   <= {sr[SYNC-2:0], din};
         prev <= sr[SYNC-1];
      end
   end

   assign rise = sr[SYNC-1] && !prev;
   assign fall = !sr[SYNC-1] && prev;

   always_comb begin
      unique case (edge_sel_e'(edge_sel))
         EDGE_RISE: evt = rise;
         EDGE_FALL: evt = fall;
         EDGE_BOTH: evt = rise || fall;
         default:   evt = 1'b0;
      endcase
   end

   // R5: with no edge selected there is never a strobe
   a_r5_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel == 2'd0) |-> !evt);
endmodule

// File: rtl/cct_chan.sv
module cct_chan #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          up,
   input  logic          step,
   input  logic          ld,
   input  logic [CW-1:0] ld_val,
   input  logic          clr,
   output logic [CW-1:0] cnt,
   output logic          wrap
);
   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (ld)     cnt <= ld_val;
      else if (clr)    cnt <= '0;
      else if (step)   cnt <= up ? cnt + 1'b1 : cnt - 1'b1;
   end

   assign wrap = step && (up ? (cnt == '1) : (cnt == '0));

   // R2: an up step with no load or clear adds one
   a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step && up && !ld && !clr) |=> cnt == CW'($past(cnt) + 1'b1));
   // R3: a down step with no load or clear subtracts one
   a_r3_down_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !up && !ld && !clr) |=> cnt == CW'($past(cnt) - 1'b1));
   // R11: clear without load empties the counter
   a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !ld) |=> cnt == '0);
endmodule

// File: rtl/cascap_timer.sv
module cascap_timer #(
   parameter int CW    = 16,
   parameter int N_AUX = 4,
   parameter int SYNC  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_t1,
   input  logic          bus_t2,
   input  logic          bus_we,
   input  logic [3:0]    bus_addr,
   input  logic [CW-1:0] bus_wdata,
   output logic [CW-1:0] bus_rdata,
   input  logic          count_en,
   input  logic          dir_lo,
   input  logic          dir_hi,
   input  logic          clr_both,
   input  logic          cap_in,
   input  logic [1:0]    edge_sel,
   input  logic          buf_en,
   output logic          cmp_a_o,
   output logic          carry_o
);
   import cct_pkg::*;

   localparam int AW = 4;

   if (CW < 2 || CW > 32) begin : g_bad_cw
      $error("cascap_timer: CW out of range");
   end
   if (N_AUX < 1 || N_AUX > 8) begin : g_bad_aux
      $error("cascap_timer: N_AUX must be 1..8");
   end

   logic [AW-1:0] acc_addr;
   logic          wr_stb, rd_stb;
   logic          cap_evt;
   logic [CW-1:0] lo_cnt, hi_cnt;
   logic          lo_wrap, hi_wrap_unused;
   logic          wr_lo, wr_hi, wr_cap, wr_buf, wr_cmp, wr_regb;
   logic          carry_evt, hi_tick, cmp_hit;
   logic [CW-1:0] lo_cap, lo_buf, hi_cmp, hi_regb;
   logic [CW-1:0] aux [N_AUX];
   logic [CW-1:0] rd_mux;

   cct_bus #(.AW(AW)) u_bus (
      .clk(clk), .rst_n(rst_n), .t1(bus_t1), .t2(bus_t2), .we(bus_we),
      .addr(bus_addr), .acc_addr(acc_addr), .wr_stb(wr_stb), .rd_stb(rd_stb)
   );

   cct_capsync #(.SYNC(SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(cap_in), .edge_sel(edge_sel), .evt(cap_evt)
   );

   assign wr_lo   = wr_stb && (acc_addr == A_LO_CNT);
   assign wr_hi   = wr_stb && (acc_addr == A_HI_CNT);
   assign wr_cap  = wr_stb && (acc_addr == A_LO_CAP);
   assign wr_buf  = wr_stb && (acc_addr == A_LO_BUF);
   assign wr_cmp  = wr_stb && (acc_addr == A_HI_CMP);
   assign wr_regb = wr_stb && (acc_addr == A_HI_REGB);

   cct_chan #(.CW(CW)) u_lo (
      .clk(clk), .rst_n(rst_n), .up(dir_lo), .step(count_en && !clr_both),
      .ld(wr_lo), .ld_val(bus_wdata), .clr(clr_both), .cnt(lo_cnt), .wrap(lo_wrap)
   );

   // carry event exists even when a lower write suppresses the step it causes
   assign carry_evt = lo_wrap;
   assign hi_tick   = carry_evt && !wr_lo;
   assign cmp_hit   = carry_evt && (hi_cnt == hi_cmp);

   cct_chan #(.CW(CW)) u_hi (
      .clk(clk), .rst_n(rst_n), .up(dir_hi), .step(hi_tick),
      .ld(wr_hi), .ld_val(bus_wdata), .clr(clr_both), .cnt(hi_cnt), .wrap(hi_wrap_unused)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_cap  <= '0;
         lo_buf  <= '0;
         hi_cmp  <= '0;
         hi_regb <= '0;
         cmp_a_o <= 1'b0;
         carry_o <= 1'b0;
      end else begin
         if (cap_evt)     lo_cap <= lo_cnt;
         else if (wr_cap) lo_cap <= bus_wdata;
         if (cap_evt && buf_en) lo_buf <= lo_cap;
         else if (wr_buf)       lo_buf <= bus_wdata;
         if (wr_cmp)      hi_cmp <= bus_wdata;
         if (cmp_hit)      hi_regb <= hi_cnt;
         else if (wr_regb) hi_regb <= bus_wdata;
         cmp_a_o <= cmp_hit;
         carry_o <= hi_tick;
      end
   end

   for (genvar k = 0; k < N_AUX; k++) begin : g_aux
      always_ff @(posedge clk) begin
         if (!rst_n)         aux[k] <= '0;
         else if (carry_evt) aux[k] <= hi_cnt;
      end
   end

   always_comb begin
      rd_mux = '0;
      unique case (acc_addr)
         A_LO_CNT:  rd_mux = lo_cnt;
         A_HI_CNT:  rd_mux = hi_cnt;
         A_LO_CAP:  rd_mux = lo_cap;
         A_LO_BUF:  rd_mux = lo_buf;
         A_HI_CMP:  rd_mux = hi_cmp;
         A_HI_REGB: rd_mux = hi_regb;
         default: begin
            for (int k = 0; k < N_AUX; k++)
               if (acc_addr == AW'(int'(A_AUX0) + k)) rd_mux = aux[k];
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_stb) bus_rdata <= rd_mux;
   end

   // R7: a buffered capture moves the capture value, whatever the bus writes
   a_r7_buf_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt && buf_en) |=> lo_buf == $past(lo_cap));
   // R8: a lower write over a wrap leaves the upper half untouched
   a_r8_carry_held: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && lo_wrap && !wr_hi && !clr_both) |=> (hi_cnt == $past(hi_cnt)) && !carry_o);
   // R9: a compare pulse is always preceded by a carry event
   a_r9_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_a_o |-> $past(carry_evt));
   // R12: a delivered carry moves the upper counter
   a_r12_carry_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_tick && !wr_hi && !clr_both) |=> hi_cnt != $past(hi_cnt));
endmodule

// File: tb/test_cascap_timer.sv
module test_cascap_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_t1 = 0, bus_t2 = 0, bus_we = 0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        count_en = 0, dir_lo = 1, dir_hi = 1, clr_both = 0;
   logic        cap_in = 0, buf_en = 0;
   logic [1:0]  edge_sel = 2'd0;
   logic        cmp_a_o, carry_o;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   cascap_timer i_cascap_timer (
      .clk(clk), .rst_n(rst_n), .bus_t1(bus_t1), .bus_t2(bus_t2), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .count_en(count_en), .dir_lo(dir_lo), .dir_hi(dir_hi), .clr_both(clr_both),
      .cap_in(cap_in), .edge_sel(edge_sel), .buf_en(buf_en),
      .cmp_a_o(cmp_a_o), .carry_o(carry_o)
   );

   function automatic logic [31:0] model32(logic [31:0] v, bit up, int n);
      return up ? v + 32'(n) : v - 32'(n);
   endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [15:0] d);
      @(negedge clk); bus_t1 = 1; bus_we = 1; bus_addr = a;
      @(negedge clk); bus_t1 = 0; bus_t2 = 1; bus_wdata = d;
      @(negedge clk); bus_t2 = 0; bus_we = 0;
   endtask

   task automatic rd(logic [3:0] a, output logic [15:0] d);
      @(negedge clk); bus_t1 = 1; bus_we = 0; bus_addr = a;
      @(negedge clk); bus_t1 = 0; bus_t2 = 1;
      @(negedge clk); bus_t2 = 0; d = bus_rdata;
   endtask

   task automatic tick(int n);
      @(negedge clk); count_en = 1;
      repeat (n - 1) @(negedge clk);
      @(negedge clk); count_en = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] d, d2;
      logic [31:0] e32;
      logic [15:0] cap_prev;
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      repeat (4) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      foreach (d2[i]) begin end
      for (int a = 0; a < 12; a++) begin
         rd(4'(a), d);
         check("R1 reset reg", {16'h0, d}, 32'h0);
      end
      check("R1 cmp_a_o", {31'h0, cmp_a_o}, 32'h0);
      check("R1 carry_o", {31'h0, carry_o}, 32'h0);

      // R4 write/read of writable registers, unmapped reads zero
      for (int a = 2; a < 6; a++) begin
         d2 = 16'($urandom);
         wr(4'(a), d2);
         rd(4'(a), d);
         check("R4 readback", {16'h0, d}, {16'h0, d2});
      end
      rd(4'd7, d);
      check("R4 unmapped", {16'h0, d}, 32'h0);

      // R4 read returns T2 value while counting
      wr(4'd0, 16'd100);
      @(negedge clk); count_en = 1; bus_t1 = 1; bus_we = 0; bus_addr = 4'd0;
      @(negedge clk); bus_t1 = 0; bus_t2 = 1;
      @(negedge clk); bus_t2 = 0; count_en = 0;
      check("R4 read sampled in T2", {16'h0, bus_rdata}, 32'd101);
      rd(4'd0, d);
      check("R4 count after read", {16'h0, d}, 32'd102);

      // R2/R3 random cascade runs against a 32-bit model
      for (int it = 0; it < 24; it++) begin
         bit up;
         int n;
         logic [15:0] lo0, hi0;
         up = 1'($urandom);
         n = 1 + int'($urandom % 300);
         hi0 = 16'($urandom);
         lo0 = up ? 16'(16'hFFFF - ($urandom % 64)) : 16'($urandom % 64);
         dir_lo = up; dir_hi = up;
         wr(4'd0, lo0);
         wr(4'd1, hi0);
         tick(n);
         e32 = model32({hi0, lo0}, up, n);
         rd(4'd0, d);
         rd(4'd1, d2);
         if (up) check("R2 cascade up", {d2, d}, e32);
         else    check("R3 cascade down", {d2, d}, e32);
      end

      // R3 directed borrow
      dir_lo = 0; dir_hi = 0;
      wr(4'd0, 16'h0000); wr(4'd1, 16'd5);
      tick(1);
      rd(4'd0, d); rd(4'd1, d2);
      check("R3 borrow", {d2, d}, {16'd4, 16'hFFFF});
      dir_lo = 1; dir_hi = 1;

      // R11 clear both halves together
      wr(4'd0, 16'h1234); wr(4'd1, 16'h4321);
      @(negedge clk); clr_both = 1; count_en = 1;
      @(negedge clk); clr_both = 0; count_en = 0;
      rd(4'd0, d); rd(4'd1, d2);
      check("R11 clear", {d2, d}, 32'h0);

      // R5 capture edges
      buf_en = 0; edge_sel = 2'd1;
      wr(4'd0, 16'd500);
      @(negedge clk); cap_in = 1; repeat (4) @(negedge clk);
      rd(4'd2, d);
      check("R5 rising capture", {16'h0, d}, 32'd500);
      wr(4'd0, 16'd600);
      @(negedge clk); cap_in = 0; repeat (4) @(negedge clk);
      rd(4'd2, d);
      check("R5 falling ignored", {16'h0, d}, 32'd500);
      edge_sel = 2'd2;
      wr(4'd0, 16'd700);
      @(negedge clk); cap_in = 1; repeat (4) @(negedge clk);
      rd(4'd2, d);
      check("R5 rising ignored", {16'h0, d}, 32'd500);
      @(negedge clk); cap_in = 0; repeat (4) @(negedge clk);
      rd(4'd2, d);
      check("R5 falling capture", {16'h0, d}, 32'd700);
      edge_sel = 2'd0;
      wr(4'd0, 16'd710);
      @(negedge clk); cap_in = 1; repeat (4) @(negedge clk);
      rd(4'd2, d);
      check("R5 none ignored", {16'h0, d}, 32'd700);
      edge_sel = 2'd3;
      @(negedge clk); cap_in = 0; repeat (4) @(negedge clk);
      rd(4'd2, d);
      check("R5 both edges", {16'h0, d}, 32'd710);

      // R6 buffered capture
      buf_en = 1; edge_sel = 2'd1;
      wr(4'd0, 16'd800);
      cap_prev = 16'd710;
      @(negedge clk); cap_in = 1; repeat (4) @(negedge clk);
      rd(4'd2, d); rd(4'd3, d2);
      check("R6 capture", {16'h0, d}, 32'd800);
      check("R6 buffer", {16'h0, d2}, {16'h0, cap_prev});

      // R7 buffer write collides with capture
      @(negedge clk); cap_in = 0; repeat (4) @(negedge clk);
      wr(4'd0, 16'd900);
      @(negedge clk); cap_in = 1;
      @(negedge clk); bus_t1 = 1; bus_we = 1; bus_addr = 4'd3;
      @(negedge clk); bus_t1 = 0; bus_t2 = 1; bus_wdata = 16'hBEEF;
      @(negedge clk); bus_t2 = 0; bus_we = 0;
      rd(4'd3, d); rd(4'd2, d2);
      check("R7 buffer write discarded", {16'h0, d}, 32'd800);
      check("R7 capture taken", {16'h0, d2}, 32'd900);
      buf_en = 0;

      // R8/R9/R10 lower write collides with wrap
      wr(4'd0, 16'hFFFF); wr(4'd1, 16'h5A5A);
      wr(4'd4, 16'h5A5A); wr(4'd5, 16'h0000);
      @(negedge clk); bus_t1 = 1; bus_we = 1; bus_addr = 4'd0;
      @(negedge clk); bus_t1 = 0; bus_t2 = 1; bus_wdata = 16'h1234; count_en = 1;
      @(negedge clk); bus_t2 = 0; bus_we = 0; count_en = 0;
      check("R8 no carry_o", {31'h0, carry_o}, 32'h0);
      check("R9 compare in conflict", {31'h0, cmp_a_o}, 32'h1);
      rd(4'd0, d); rd(4'd1, d2);
      check("R8 written value", {16'h0, d}, 32'h1234);
      check("R8 upper held", {16'h0, d2}, 32'h5A5A);
      rd(4'd5, d);
      check("R9 regb captured", {16'h0, d}, 32'h5A5A);
      for (int k = 0; k < 4; k++) begin
         rd(4'(8 + k), d);
         check("R10 aux in conflict", {16'h0, d}, 32'h5A5A);
      end

      // R9/R12 normal carry with match, then without
      wr(4'd0, 16'hFFFF); wr(4'd5, 16'h0000);
      @(negedge clk); count_en = 1;
      @(negedge clk); count_en = 0;
      check("R12 carry pulse", {31'h0, carry_o}, 32'h1);
      check("R9 compare pulse", {31'h0, cmp_a_o}, 32'h1);
      @(negedge clk);
      check("R12 carry one cycle", {31'h0, carry_o}, 32'h0);
      rd(4'd1, d); rd(4'd5, d2);
      check("R2 upper stepped", {16'h0, d}, 32'h5A5B);
      check("R9 regb on match", {16'h0, d2}, 32'h5A5A);
      wr(4'd0, 16'hFFFF);
      @(negedge clk); count_en = 1;
      @(negedge clk); count_en = 0;
      check("R9 no pulse on mismatch", {31'h0, cmp_a_o}, 32'h0);
      rd(4'd5, d); rd(4'd8, d2);
      check("R9 regb held on mismatch", {16'h0, d}, 32'h5A5A);
      check("R10 aux every carry", {16'h0, d2}, 32'h5A5B);

      finish_run();
   end
endmodule